// File: doc/BRIEF.md
# Enhanced Parallel Port Host Cycle Engine

This block is the host half of an enhanced parallel port. The host reaches it through a small register window of eight byte offsets. A write or read at the address offset or at any of the four data offsets becomes one handshaked transfer on the 8-bit peripheral data lines. The engine drives the direction line (low for a write), the address strobe or the data strobe, and the data lines. It follows the peripheral's wait line and keeps the host ready line low for the whole transfer.

A transfer ends when the peripheral deasserts its wait line. If the peripheral does not respond within a parameter-set number of clocks, the engine ends the transfer on its own and sets a sticky timeout flag. Software clears the flag by writing a one to it. The mode is enabled through a control bit. The enable is blocked while a strap input reports bit 2 of the port's base address as set. The peripheral wait line passes through a synchronizer before the engine uses it.

Top module: `epp_host_engine`

## Requirements
- R1: After reset, host_ready is 1, par_write_n, par_astb_n and par_dstb_n are 1, par_oe is 0, the enable bit is 0 and the timeout flag is 0.
- R2: With the mode active, a host write at offset 4, 5, 6 or 7 is accepted at the next clock edge. From then on, par_write_n and par_dstb_n are 0, par_dout equals the written byte, par_oe is 1 and host_ready is 0.
- R3: A host write or read at offset 3 drives par_astb_n low instead of par_dstb_n. par_dstb_n stays 1 throughout.
- R4: Let par_wait_n rise between clock edges. The strobe is still low after the second edge and is released at the third edge. par_write_n returns to 1 one edge later. par_dout stays constant while par_write_n is low. Once par_wait_n falls again, host_ready returns to 1 at the third edge after the fall.
- R5: A host read at offset 3 to 7 keeps par_write_n at 1 and par_oe at 0. The byte on par_din at the edge that ends the strobe appears on host_rdata by the time host_ready returns to 1.
- R6: If no deasserted wait is seen within TIMEOUT_CLKS edges after the strobe went low, the strobe is released at edge TIMEOUT_CLKS after the accepting edge. The timeout flag is set, and a read that timed out returns 0xFF on host_rdata. With par_wait_n low, host_ready returns two edges later.
- R7: Writing offset 1 with bit 0 set clears the timeout flag. Writing it with bit 0 clear leaves the flag unchanged.
- R8: Reading offset 1 returns the status byte. Bit 0 holds the timeout flag while the mode is active and always reads 1 while it is not. Bit 1 holds the mode-active state. Bits 7:2 read 0.
- R9: Offset 2 bit 0 is the mode enable and reads back as written. The mode is active only when that bit is 1 and base_bit2 is 0.
- R10: While the mode is not active, host accesses at offsets 3 to 7 start no transfer: the strobes stay 1 and host_ready stays 1.
- R11: A host request at offsets 3 to 7 that arrives while a transfer is in progress is dropped. It changes neither par_dout nor the transfer, and it does not start a transfer afterwards.
- R12: A host read at offset 1 or 2 presents its value on host_rdata one clock edge after the read pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_bit2 | input | 1 | Strap showing bit 2 of the port base address; 1 blocks the mode |
| host_addr | input | 3 | Register offset within the window |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Single-cycle host write pulse |
| host_rd | input | 1 | Single-cycle host read pulse |
| host_rdata | output | 8 | Registered host read byte |
| host_ready | output | 1 | Host bus ready; low while a transfer is running |
| par_dout | output | 8 | Byte driven toward the peripheral |
| par_din | input | 8 | Byte seen on the peripheral data lines |
| par_oe | output | 1 | Output enable for par_dout |
| par_write_n | output | 1 | Direction line, low during a write transfer |
| par_astb_n | output | 1 | Address strobe, active low |
| par_dstb_n | output | 1 | Data strobe, active low |
| par_wait_n | input | 1 | Peripheral wait line; high means the peripheral is done |

## Verification
A transfer's pins change one edge after the host pulse. A change on par_wait_n reaches the engine two edges later through the synchronizer and acts one edge after that. The strobe release is therefore due at the third edge after a wait rise, the direction release one edge later, and the ready return at the third edge after the wait fall. A register read is due one edge after its pulse, and a timeout ends the strobe exactly TIMEOUT_CLKS edges after acceptance. The bench drives and samples only at falling edges and counts falling edges from each stimulus, so every check lands on the first sample where its result is due. It also checks the sample just before, where the old value must still hold.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

    localparam int DATA_W = 8;
    localparam int OFS_W  = 3;

    localparam logic [OFS_W-1:0] OFS_STATUS   = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CTRL     = 3'd2;
    localparam logic [OFS_W-1:0] OFS_EPP_ADDR = 3'd3;

    localparam logic [DATA_W-1:0] TIMEOUT_READ_VAL = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STRB  = 2'd1,
        ST_END   = 2'd2,
        ST_RECOV = 2'd3
    } cyc_state_e;

    typedef struct packed {
        logic              is_write;
        logic              is_addr;
        logic [DATA_W-1:0] data;
    } cyc_req_t;

    function automatic logic is_xfer_ofs(input logic [OFS_W-1:0] ofs);
        return ofs >= OFS_EPP_ADDR;
    endfunction

    function automatic logic is_addr_ofs(input logic [OFS_W-1:0] ofs);
        return ofs == OFS_EPP_ADDR;
    endfunction

endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) q[0] <= 1'b0;
                    else     q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) q[g] <= 1'b0;
                    else     q[g] <= q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = q[STAGES-1];
endmodule

// File: rtl/epp_cfg_regs.sv
module epp_cfg_regs
    import epp_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              base_bit2,
    input  logic [OFS_W-1:0]  host_addr,
    input  logic              host_bit0,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              set_timeout,
    input  logic              xfer_rd_done,
    input  logic [DATA_W-1:0] xfer_rd_data,
    output logic              mode_active,
    output logic [DATA_W-1:0] host_rdata
);
    logic en_q;
    logic to_q;
    logic wr_status;
    logic wr_ctrl;
    logic [DATA_W-1:0] status_view;

    assign wr_status   = host_wr && (host_addr == OFS_STATUS);
    assign wr_ctrl     = host_wr && (host_addr == OFS_CTRL);
    assign mode_active = en_q && !base_bit2;
    assign status_view = {6'd0, mode_active, (mode_active ? to_q : 1'b1)};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            to_q <= 1'b0;
        end else begin
            if (wr_ctrl) en_q <= host_bit0;
            if (set_timeout)                 to_q <= 1'b1;
            else if (wr_status && host_bit0) to_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (xfer_rd_done) begin
            host_rdata <= xfer_rd_data;
        end else if (host_rd && !is_xfer_ofs(host_addr)) begin
            case (host_addr)
                OFS_STATUS: host_rdata <= status_view;
                OFS_CTRL:   host_rdata <= {7'd0, en_q};
                default:    host_rdata <= '0;
            endcase
        end
    end

    // R7: a write-one to the status offset leaves the flag cleared
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        $past(wr_status && host_bit0 && !set_timeout) |-> !to_q);

    // R6: a timeout event always leaves the flag set
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(set_timeout) |-> to_q);

    // R9: the strap blocks the mode whatever the enable bit holds
    a_r9_strap_blocks: assert property (@(posedge clk) disable iff (rst)
        base_bit2 |-> !mode_active);
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
    import epp_host_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 2500,
    localparam int CNT_W = $clog2(TIMEOUT_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_active,
    input  logic [OFS_W-1:0]  host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              wait_seen,
    input  logic [DATA_W-1:0] par_din,
    output logic [DATA_W-1:0] par_dout,
    output logic              par_oe,
    output logic              par_write_n,
    output logic              par_astb_n,
    output logic              par_dstb_n,
    output logic              host_ready,
    output logic              set_timeout,
    output logic              xfer_rd_done,
    output logic [DATA_W-1:0] xfer_rd_data
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CLKS - 1);

    cyc_state_e       state;
    cyc_req_t         req;
    logic [CNT_W-1:0] cnt;
    logic             start;
    logic             expired;
    logic             strobe_phase;

    assign start   = (state == ST_IDLE) && mode_active &&
                     is_xfer_ofs(host_addr) && (host_wr || host_rd);
    assign expired = (state == ST_STRB) && !wait_seen && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req   <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req.is_write <= host_wr;
                        req.is_addr  <= is_addr_ofs(host_addr);
                        req.data     <= host_wdata;
                        cnt          <= '0;
                        state        <= ST_STRB;
                    end
                end
                ST_STRB: begin
                    if (wait_seen || expired) state <= ST_END;
                    else                      cnt   <= cnt + 1'b1;
                end
                ST_END:   state <= ST_RECOV;
                ST_RECOV: if (!wait_seen) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign strobe_phase = (state == ST_STRB);
    assign par_astb_n   = !(strobe_phase && req.is_addr);
    assign par_dstb_n   = !(strobe_phase && !req.is_addr);
    assign par_write_n  = !(req.is_write && (strobe_phase || state == ST_END));
    assign par_oe       = req.is_write && (state != ST_IDLE);
    assign par_dout     = req.data;
    assign host_ready   = (state == ST_IDLE);

    assign set_timeout  = expired;
    assign xfer_rd_done = strobe_phase && !req.is_write && (wait_seen || expired);
    assign xfer_rd_data = wait_seen ? par_din : TIMEOUT_READ_VAL;

    // R4: the direction line is released only after both strobes are high
    a_r4_write_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(par_write_n) |-> $past(par_astb_n && par_dstb_n));

    // R4: the write byte holds while the direction line stays low
    a_r4_data_stable: assert property (@(posedge clk) disable iff (rst)
        (!par_write_n && $past(!par_write_n)) |-> $stable(par_dout));

    // R10: a strobe only starts when the mode was active
    a_r10_start_needs_mode: assert property (@(posedge clk) disable iff (rst)
        ($fell(par_astb_n) || $fell(par_dstb_n)) |-> $past(mode_active));

    // R11: a running transfer keeps its captured request
    a_r11_busy_keeps_req: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && $past(state != ST_IDLE)) |-> $stable(req));

    // R6: the strobe phase never outlasts the timeout window
    a_r6_window_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STRB) |-> (cnt <= CNT_LAST));
endmodule

// File: rtl/epp_host_engine.sv
module epp_host_engine
    import epp_host_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 2500,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_bit2,
    input  logic [OFS_W-1:0]  host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] par_dout,
    input  logic [DATA_W-1:0] par_din,
    output logic              par_oe,
    output logic              par_write_n,
    output logic              par_astb_n,
    output logic              par_dstb_n,
    input  logic              par_wait_n
);
    logic              wait_seen;
    logic              mode_active;
    logic              set_timeout;
    logic              xfer_rd_done;
    logic [DATA_W-1:0] xfer_rd_data;

    epp_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (par_wait_n),
        .sync_out (wait_seen)
    );

    epp_cycle_fsm #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .mode_active  (mode_active),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .wait_seen    (wait_seen),
        .par_din      (par_din),
        .par_dout     (par_dout),
        .par_oe       (par_oe),
        .par_write_n  (par_write_n),
        .par_astb_n   (par_astb_n),
        .par_dstb_n   (par_dstb_n),
        .host_ready   (host_ready),
        .set_timeout  (set_timeout),
        .xfer_rd_done (xfer_rd_done),
        .xfer_rd_data (xfer_rd_data)
    );

    epp_cfg_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .base_bit2    (base_bit2),
        .host_addr    (host_addr),
        .host_bit0    (host_wdata[0]),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .set_timeout  (set_timeout),
        .xfer_rd_done (xfer_rd_done),
        .xfer_rd_data (xfer_rd_data),
        .mode_active  (mode_active),
        .host_rdata   (host_rdata)
    );

    // R1: while idle nothing is strobed and the lines are not driven
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (par_astb_n && par_dstb_n && par_write_n && !par_oe));
endmodule

// File: tb/epp_host_engine_tb.sv
`timescale 1ns/1ps
module epp_host_engine_tb;
    localparam int TO = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_bit2 = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       host_ready;
    logic [7:0] par_dout;
    logic [7:0] par_din = '0;
    logic       par_oe;
    logic       par_write_n;
    logic       par_astb_n;
    logic       par_dstb_n;
    logic       par_wait_n = 1'b0;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    epp_host_engine #(.TIMEOUT_CLKS(TO), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .base_bit2(base_bit2),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_ready(host_ready),
        .par_dout(par_dout), .par_din(par_din), .par_oe(par_oe),
        .par_write_n(par_write_n), .par_astb_n(par_astb_n),
        .par_dstb_n(par_dstb_n), .par_wait_n(par_wait_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=done", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic nstep(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, input string tag, input int exp);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        chk(tag, host_rdata, exp);
    endtask

    function automatic int strobes_of(input logic [2:0] ofs);
        // {astb_n, dstb_n} while the strobe is active
        return (ofs == 3'd3) ? 2'b01 : 2'b10;
    endfunction

    task automatic xfer(input bit wr, input logic [2:0] ofs, input logic [7:0] d,
                        input int dly, input logic [7:0] pin, input bit inj);
        string t;
        t = wr ? ((ofs == 3'd3) ? "R3" : "R2") : ((ofs == 3'd3) ? "R3" : "R5");
        @(negedge clk);
        host_wr = wr; host_rd = !wr; host_addr = ofs; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        chk({t, " strobes"}, {par_astb_n, par_dstb_n}, strobes_of(ofs));
        chk({t, " write_n"}, par_write_n, !wr);
        chk({t, " oe"}, par_oe, wr);
        chk({t, " ready low"}, host_ready, 0);
        if (wr) chk({t, " dout"}, par_dout, d);
        if (inj) begin
            host_wr = 1'b1; host_addr = 3'd6; host_wdata = ~d;
        end
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            host_wr = 1'b0;
        end
        par_wait_n = 1'b1; par_din = pin;
        nstep(2);
        chk("R4 strobe held before release", {par_astb_n, par_dstb_n}, strobes_of(ofs));
        nstep(1);
        chk("R4 strobe released", {par_astb_n, par_dstb_n}, 2'b11);
        chk("R4 write_n lags strobe", par_write_n, !wr);
        chk("R4 ready still low", host_ready, 0);
        if (inj) chk("R11 dout unchanged", par_dout, d);
        par_wait_n = 1'b0;
        nstep(1);
        chk("R4 write_n released", par_write_n, 1);
        chk("R4 ready low in recovery", host_ready, 0);
        nstep(1);
        chk("R4 ready low before wait seen", host_ready, 0);
        nstep(1);
        chk("R4 ready back", host_ready, 1);
        chk("R4 oe off", par_oe, 0);
        if (!wr) chk({t, " read byte"}, host_rdata, pin);
        if (inj) begin
            nstep(3);
            chk("R11 no queued transfer", {host_ready, par_astb_n, par_dstb_n}, 3'b111);
        end
    endtask

    task automatic xfer_timeout(input bit wr, input logic [2:0] ofs, input logic [7:0] d);
        @(negedge clk);
        host_wr = wr; host_rd = !wr; host_addr = ofs; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        nstep(TO - 1);
        chk("R6 strobe held to limit", {par_astb_n, par_dstb_n}, strobes_of(ofs));
        nstep(1);
        chk("R6 strobe ended by timeout", {par_astb_n, par_dstb_n}, 2'b11);
        nstep(1);
        chk("R6 ready low after timeout", host_ready, 0);
        nstep(1);
        chk("R6 ready back after timeout", host_ready, 1);
        if (!wr) chk("R6 timed-out read value", host_rdata, 8'hFF);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        nstep(4);
        rst = 1'b0;
        nstep(1);
        chk("R1 ready", host_ready, 1);
        chk("R1 strobes/write", {par_astb_n, par_dstb_n, par_write_n}, 3'b111);
        chk("R1 oe", par_oe, 0);
        reg_rd(3'd1, "R8 status inactive R12", 8'h01);
        reg_rd(3'd2, "R9 ctrl reset R1", 8'h00);

        // inactive: no transfer
        @(negedge clk); host_wr = 1'b1; host_addr = 3'd4; host_wdata = 8'h11;
        @(negedge clk); host_wr = 1'b0;
        nstep(2);
        chk("R10 no strobe inactive", {host_ready, par_astb_n, par_dstb_n}, 3'b111);

        // strap blocks mode
        base_bit2 = 1'b1;
        reg_wr(3'd2, 8'h01);
        reg_rd(3'd2, "R9 ctrl readback", 8'h01);
        reg_rd(3'd1, "R9 strap blocks", 8'h01);
        @(negedge clk); host_rd = 1'b1; host_addr = 3'd3;
        @(negedge clk); host_rd = 1'b0;
        nstep(2);
        chk("R10 no strobe with strap", {host_ready, par_astb_n, par_dstb_n}, 3'b111);
        base_bit2 = 1'b0;
        reg_rd(3'd1, "R8 status active", 8'h02);

        // directed transfers
        xfer(1, 3'd4, 8'hA5, 0, 8'h00, 0);
        xfer(1, 3'd3, 8'h3C, 3, 8'h00, 0);
        xfer(0, 3'd5, 8'h00, 5, 8'h96, 0);
        xfer(0, 3'd3, 8'h00, 1, 8'h5A, 0);
        xfer(1, 3'd7, 8'hC3, 4, 8'h00, 1);

        // timeout
        xfer_timeout(1, 3'd6, 8'h77);
        reg_rd(3'd1, "R6 flag set", 8'h03);
        reg_wr(3'd1, 8'h00);
        reg_rd(3'd1, "R7 write zero keeps flag", 8'h03);
        reg_wr(3'd1, 8'h01);
        reg_rd(3'd1, "R7 write one clears", 8'h02);
        xfer_timeout(0, 3'd3, 8'h00);
        reg_rd(3'd1, "R6 flag set by read", 8'h03);
        reg_wr(3'd2, 8'h00);
        reg_rd(3'd1, "R8 inactive reads one", 8'h01);
        reg_wr(3'd2, 8'h01);
        reg_wr(3'd1, 8'hFF);
        reg_rd(3'd1, "R7 cleared again", 8'h02);

        // random transfers
        for (int k = 0; k < 40; k++) begin
            bit wr;
            logic [2:0] ofs;
            wr  = $urandom_range(0, 1) != 0;
            ofs = 3'($urandom_range(3, 7));
            xfer(wr, ofs, 8'($urandom), $urandom_range(0, 20), 8'($urandom), 0);
        end
        reg_rd(3'd1, "R6 no spurious timeout", 8'h02);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule